// File: doc/BRIEF.md
# Transmit-Only Serial Line Driver with Byte Queue

This block turns bytes into asynchronous serial frames of one start bit, eight data bits and one stop bit, with no parity. A writer pushes bytes into a four-entry queue through a data bus and a write strobe. A bit-rate clock enable from outside sets the baud rate: every cycle in which it is high, the line moves on by exactly one bit. There is no oversampling and no internal baud divider.

Inside, an eleven-state sequencer (idle, start, eight data states, stop) steers an 8-bit shifter that has only two operations. It either loads the head of the queue or shifts right. The serial bit is the shifter's least significant bit, and it is captured into a flip-flop that drives the line. When the queue still holds a byte as the stop bit ends, the next start bit follows at once. The not-full flag can serve as a DMA request. The idle flag tells software that the last frame has fully left the wire.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset, tx is 1, tx_idle is 1 and not_full is 1.
- R2: Each frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit.
- R3: The sequencer and tx change only on a clock edge where bit_en is 1, and tx changes on that edge itself. Each frame bit therefore lasts from one bit_en cycle to the next.
- R4: If the queue is not empty when the stop bit's interval ends, the start bit of the next frame follows with no idle bit in between.
- R5: The queue holds four bytes. not_full is 0 while it holds four, and a write strobe while not_full is 0 is dropped.
- R6: A byte leaves the queue on the bit_en edge that begins its start bit, so not_full reads 1 in the cycle after that edge.
- R7: tx_idle is 1 exactly when no frame is on the line and the queue is empty. While tx_idle is 1, tx is 1.
- R8: Accepted bytes are transmitted in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per bit period |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to queue |
| not_full | output | 1 | Queue can accept a byte; usable as a DMA request |
| tx_idle | output | 1 | Line idle and queue empty |
| tx | output | 1 | Registered serial output, high when idle |

## Verification
The assertions check on every cycle that tx holds when bit_en is low, that the start bit reads low and the stop bit high, that the queue count never exceeds its depth, that a write into a full queue leaves the count alone, and that a frame begins whenever a bit_en finds bytes waiting at idle or stop. Only the bench's scenarios can show the order of bits and bytes on the wire, back-to-back frames with no gap, and the exact cycle in which not_full returns. The bench shows these by decoding the line and by running a behavioural queue model that is compared on every clock, under regular, sparse and irregular bit_en patterns.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       not_full,
  output logic       tx_idle,
  output logic       tx
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [3:0] S_IDLE  = 4'd0;
  localparam logic [3:0] S_START = 4'd1;
  localparam logic [3:0] S_D7    = 4'd9;
  localparam logic [3:0] S_STOP  = 4'd10;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [AW:0]   cnt;
  logic [3:0]    st;
  logic [7:0]    sh;
  logic          tx_q;

  wire empty = (cnt == '0);
  wire full  = (cnt == FULL_CNT);
  wire push  = wr_en && !full;
  wire load  = bit_en && !empty && (st == S_IDLE || st == S_STOP);

  assign not_full = !full;
  assign tx_idle  = (st == S_IDLE) && empty;
  assign tx       = tx_q;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (load) rp <= rp + 1'b1;
      case ({push, load})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      sh   <= '0;
      tx_q <= 1'b1;
    end else if (bit_en) begin
      if (load) begin
        sh   <= mem[rp];
        st   <= S_START;
        tx_q <= 1'b0;
      end else begin
        sh <= sh >> 1;
        case (st)
          S_IDLE, S_STOP: begin
            st   <= S_IDLE;
            tx_q <= 1'b1;
          end
          S_D7: begin
            st   <= S_STOP;
            tx_q <= 1'b1;
          end
          default: begin
            st   <= st + 4'd1;
            tx_q <= sh[0];
          end
        endcase
      end
    end
  end

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(bit_en) && !$past(rst)) |-> $stable(tx))
    else $error("tx moved without bit_en");

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_START) |-> !tx)
    else $error("start bit not low");

  assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_STOP) |-> tx)
    else $error("stop bit not high");

  assert_idle_line_R7: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> tx)
    else $error("line low while idle");

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT)
    else $error("queue count above depth");

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !load) |=> (cnt == FULL_CNT))
    else $error("write into full queue changed count");

  assert_frame_start_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !empty && (st == S_IDLE || st == S_STOP)) |=> (st == S_START))
    else $error("frame did not start with bytes waiting");
endmodule

// File: tb/tb_uart_tx_fifo.sv
module tb_uart_tx_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic not_full, tx_idle, tx;

  uart_tx_fifo dut (.clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en),
                    .wr_data(wr_data), .not_full(not_full), .tx_idle(tx_idle), .tx(tx));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int en_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] q[$];
  logic [7:0] sent[$];
  int ph = -1;
  logic [7:0] cur = 0;
  bit en_seen = 0;
  int rx_ph = 0;
  logic [7:0] rxb = 0;
  int frames = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit do_wr;
    cycles++;
    en_seen = bit_en && !rst;
    if (rst) begin
      q.delete(); ph = -1; rx_ph = 0;
    end else begin
      do_wr = wr_en && (q.size() < 4);
      if (bit_en) begin
        if ((ph == -1 || ph == 9) && q.size() > 0) begin
          cur = q.pop_front(); ph = 0;
        end else if (ph == 9) ph = -1;
        else if (ph >= 0) ph++;
      end
      if (do_wr) begin
        q.push_back(wr_data); sent.push_back(wr_data);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int etx;
      if (ph == -1 || ph == 9) etx = 1;
      else if (ph == 0) etx = 0;
      else etx = cur[ph-1];
      chk("R2/R3/R4 tx", tx, etx);
      chk("R5/R6 not_full", not_full, q.size() < 4);
      chk("R7 tx_idle", tx_idle, (ph == -1) && (q.size() == 0));
      if (en_seen) begin
        if (rx_ph == 0) begin
          if (tx == 1'b0) begin rx_ph = 1; rxb = 0; end
        end else if (rx_ph <= 8) begin
          rxb[rx_ph-1] = tx; rx_ph++;
        end else begin
          chk("R2 stop bit", tx, 1);
          if (sent.size() > 0) chk("R8 byte order", rxb, sent.pop_front());
          else chk("R8 unexpected frame", 1, 0);
          frames++;
          rx_ph = 0;
        end
      end
    end
    case (en_mode)
      0: bit_en = 1'b0;
      1: bit_en = 1'b1;
      2: bit_en = (cycles % 3 == 0);
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_en = lfsr[0];
      end
    endcase
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!(tx_idle && rx_ph == 0) && n < 5000) begin @(negedge clk); n++; end
    chk("R7 reached idle", tx_idle, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx after reset", tx, 1);
    chk("R1 idle after reset", tx_idle, 1);
    chk("R1 not_full after reset", not_full, 1);

    en_mode = 1;
    wr(8'hA5);
    wait_idle();
    chk("R2 one frame decoded", frames, 1);

    en_mode = 2;
    wr(8'h01); wr(8'h80); wr(8'h3C);
    wait_idle();
    chk("R4 back-to-back frames decoded", frames, 4);

    en_mode = 0;
    for (int i = 0; i < 6; i++) wr(8'(8'h10 + i));
    chk("R5 not_full low at depth", not_full, 0);
    repeat (5) @(negedge clk);
    chk("R3 tx held without bit_en", tx, 1);
    en_mode = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not_full after first pop", not_full, 1);
    wait_idle();
    chk("R5 only four of six kept", frames, 8);

    en_mode = 3;
    wr(8'hFF); wr(8'h00);
    repeat (30) @(negedge clk);
    wr(8'h5A); wr(8'hC3); wr(8'h96);
    wait_idle();
    chk("R8 all frames sent in order", frames, 13);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule